// File: doc/BRIEF.md
# Timed Command Pulse Handshake

This block sits on the device side of a master/slave link that controls a pen-plotter style output unit. The master presents a word of command bits. When the word is nonzero and the device is ready, the block captures the word and pulls the matching device control lines low. All other lines stay high. The lines are held low for a fixed number of clock cycles and then released.

After the release the block raises a completion flag. It keeps that flag high until the master sets the command word back to all zeros, which closes a four-phase interlock. A ready input from the device decides whether a word is accepted. The inverse of that input goes back to the master as a not-ready flag. The word is sampled once, when it is accepted. Changes to the word during the pulse have no effect, and neither does a drop in ready during the pulse.

Top module: `pulse_handshake`

## Requirements
- R1: While reset is held and on the cycle after it is released, every bit of `dev_line_no` is 1 and `done_o` is 0.
- R2: An all-zero command word starts no operation: `dev_line_no` stays all ones and `done_o` stays 0.
- R3: With `dev_ready_i`=1, a nonzero `cmd_i` sampled at a clock edge makes `dev_line_no` equal to the bitwise inverse of that word from that edge on. A set command bit drives its line to 0, and a clear bit leaves its line at 1.
- R4: The lines stay at the inverted word for exactly `PULSE_CYC` clock cycles and then all return to 1.
- R5: `done_o` rises on the same edge that releases the lines.
- R6: `done_o` stays 1 while `cmd_i` is nonzero. It falls on the first edge at which `cmd_i` is sampled as all zeros.
- R7: While `dev_ready_i`=0, a nonzero `cmd_i` in the idle state is ignored: the lines stay all ones and `done_o` stays 0.
- R8: `not_ready_o` always equals the inverse of `dev_ready_i` in the same cycle.
- R9: Once a pulse has started, changes to `cmd_i` or `dev_ready_i` do not alter the lines until the pulse ends.
- R10: After `done_o` has fallen, a new nonzero word with ready high is accepted at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | CMD_W | Command bit word from the master |
| dev_ready_i | input | 1 | Device ready input (1 = ready) |
| dev_line_no | output | CMD_W | Device control lines, active low |
| done_o | output | 1 | Completion flag for the interlock |
| not_ready_o | output | 1 | Not-ready flag sent to the master |

## Verification
The capture of a word shows on the lines one edge after the word is presented. The lines stay low for the next `PULSE_CYC` samples. The sample after those shows the lines released and `done_o` high. `done_o` falls one edge after the zero word is presented, and `not_ready_o` follows ready with no delay. The bench drives inputs on the falling edge and samples just before it drives. Each expected value is therefore compared at the exact sample in which the count of edges says it is due.

// File: rtl/pulse_hs_pkg.sv
package pulse_hs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE       = 2'd0,
    ST_PULSE      = 2'd1,
    ST_WAIT_CLEAR = 2'd2
  } hs_state_e;
endpackage

// File: rtl/hs_timer.sv
module hs_timer #(
  parameter int unsigned PULSE_CYC = 16,
  localparam int unsigned CW = (PULSE_CYC > 2) ? $clog2(PULSE_CYC) : 1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expire_o
);
  localparam logic [CW-1:0] LAST = CW'(PULSE_CYC - 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      cnt_q <= '0;
    else if (load_i)                  cnt_q <= LAST;
    else if (run_i && cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign expire_o = run_i && (cnt_q == '0);

  assert_cnt_range_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= LAST);
  assert_load_full_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> cnt_q == LAST);
endmodule

// File: rtl/hs_line_drv.sv
module hs_line_drv #(
  parameter int unsigned CMD_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic             release_i,
  input  logic [CMD_W-1:0] word_i,
  output logic [CMD_W-1:0] line_no
);
  logic [CMD_W-1:0] line_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        line_q <= '1;
    else if (fire_i)    line_q <= ~word_i;
    else if (release_i) line_q <= '1;
  end

  assign line_no = line_q;

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fire_i && !release_i) |=> $stable(line_no));
endmodule

// File: rtl/pulse_handshake.sv
module pulse_handshake
  import pulse_hs_pkg::*;
#(
  parameter int unsigned CMD_W     = 8,
  parameter int unsigned PULSE_CYC = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             dev_ready_i,
  output logic [CMD_W-1:0] dev_line_no,
  output logic             done_o,
  output logic             not_ready_o
);
  hs_state_e state_q, state_d;
  logic      start, expire;

  assign start = (state_q == ST_IDLE) && (cmd_i != '0) && dev_ready_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:       if (start)         state_d = ST_PULSE;
      ST_PULSE:      if (expire)        state_d = ST_WAIT_CLEAR;
      ST_WAIT_CLEAR: if (cmd_i == '0)   state_d = ST_IDLE;
      default:                          state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE;
    else         state_q <= state_d;
  end

  hs_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .load_i   (start),
    .run_i    (state_q == ST_PULSE),
    .expire_o (expire)
  );

  hs_line_drv #(.CMD_W(CMD_W)) u_drv (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .fire_i    (start),
    .release_i (expire),
    .word_i    (cmd_i),
    .line_no   (dev_line_no)
  );

  assign done_o      = (state_q == ST_WAIT_CLEAR);
  assign not_ready_o = !dev_ready_i;

  assert_capture_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> dev_line_no == ~$past(cmd_i));
  assert_reject_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && !dev_ready_i) |=> (dev_line_no == '1 && !done_o));
  assert_idle_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE && cmd_i == '0) |=> (dev_line_no == '1 && !done_o));
  assert_release_done_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> dev_line_no == '1);
  assert_done_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && cmd_i != '0) |=> done_o);
  assert_done_lines_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> dev_line_no == '1);
endmodule

// File: tb/sim_pulse_handshake.sv
module sim_pulse_handshake;
  localparam int unsigned CMD_W = 8;
  localparam int unsigned PCYC  = 7;
  localparam time         TCLK  = 10ns;

  logic             clk = 1'b0, rst_n = 1'b0, rdy = 1'b1;
  logic [CMD_W-1:0] cmd = '0;
  logic [CMD_W-1:0] line_n;
  logic             done, nrdy;
  int               errs = 0, checks = 0;

  always #(TCLK/2) clk = ~clk;

  pulse_handshake #(.CMD_W(CMD_W), .PULSE_CYC(PCYC)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .cmd_i(cmd), .dev_ready_i(rdy),
    .dev_line_no(line_n), .done_o(done), .not_ready_o(nrdy));

  function automatic logic [CMD_W-1:0] exp_lines(input logic [CMD_W-1:0] w);
    return ~w;
  endfunction

  task automatic chk(input string req, input logic [CMD_W-1:0] l_exp,
                     input logic d_exp);
    checks++;
    if (line_n !== l_exp || done !== d_exp || nrdy !== !rdy) begin
      errs++;
      $display("FAIL %s: lines=%h done=%b nrdy=%b exp lines=%h done=%b nrdy=%b",
               req, line_n, done, nrdy, l_exp, d_exp, !rdy);
    end
  endtask

  // full handshake; word presented at a falling edge, sampled each following falling edge
  task automatic run_cmd(input logic [CMD_W-1:0] w, input int hold, input bit jitter);
    cmd = w; rdy = 1'b1;
    for (int i = 0; i < PCYC; i++) begin
      @(negedge clk);
      chk("R3/R4/R9 pulse", exp_lines(w), 1'b0);
      if (jitter) begin
        cmd = CMD_W'($urandom); rdy = 1'($urandom);
      end
    end
    if (jitter && cmd == '0) cmd = 8'h01;
    @(negedge clk);
    chk("R5 release", '1, 1'b1);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R6 hold", '1, 1'b1);
    end
    cmd = '0; rdy = 1'b1;
    @(negedge clk);
    chk("R6 clear", '1, 1'b0);
  endtask

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk); chk("R1 reset", '1, 1'b0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); chk("R1 after reset", '1, 1'b0);
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); chk("R2 zero word", '1, 1'b0);
    end
    // R7: nonzero while not ready
    rdy = 1'b0; cmd = 8'hA5;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); chk("R7/R8 not ready", '1, 1'b0);
    end
    cmd = '0; rdy = 1'b1;
    @(negedge clk); chk("R8 ready", '1, 1'b0);
    // directed corners
    run_cmd(8'h01, 0, 0);
    run_cmd(8'h80, 2, 0);
    run_cmd(8'hFF, 1, 1);
    // R10: back-to-back accept after clear
    run_cmd(8'h3C, 0, 0);
    // random mix
    for (int n = 0; n < 40; n++) begin
      logic [CMD_W-1:0] w;
      w = CMD_W'($urandom);
      if ($urandom % 4 == 0) begin
        rdy = 1'b0; cmd = (w == '0) ? 8'h11 : w;
        repeat (1 + $urandom % 3) begin
          @(negedge clk); chk("R7 random reject", '1, 1'b0);
        end
        cmd = '0; rdy = 1'b1;
        @(negedge clk); chk("R2 idle", '1, 1'b0);
      end else if (w == '0) begin
        cmd = '0;
        @(negedge clk); chk("R2 random zero", '1, 1'b0);
      end else begin
        run_cmd(w, $urandom % 3, 1'($urandom));
      end
    end
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    #(TCLK * 50000);
    errs++; checks++;
    $display("FAIL watchdog: run did not finish, exp completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule